// File: doc/BRIEF.md
# Cell DC Voltage Averaging Unit

This unit takes periodic snapshots of nine capacitor voltages from a cascaded H-bridge converter. The nine cells form three clusters of three cells each. Every cell voltage passes through a 33-tap moving-average filter. At a 4 kHz snapshot rate, 33 taps span about one period of the 120 Hz ripple that a 60 Hz grid puts on each single-phase cell. The filter therefore cancels that ripple and leaves the DC level.

From the nine filtered values the unit forms one mean per cluster. It then forms an overall mean from the three cluster means. The downstream balancing loops consume these values. One shared adder and reciprocal multiplier serve all nine channels in turn. All thirteen results are published together, with a single valid flag.

Top module: `cell_dc_avg`

## Requirements
- R1: While reset is asserted and after its release, every result output is zero and `out_valid` is low until the first snapshot is published.
- R2: Channel c occupies bits `[12c+11:12c]` of `smp_data` and of `cell_avg`. Each `cell_avg` lane equals the sum of that channel's last 33 accepted samples, divided by 33 and rounded to the nearest integer. Before 33 samples have been accepted, the missing samples count as zero.
- R3: A snapshot whose strobe is sampled high at rising edge E is published at edge E+10. All outputs change together at that edge, and they hold their values at every other edge.
- R4: Cluster k (lane `[12k+11:12k]` of `clus_avg`) covers channels 3k, 3k+1 and 3k+2. Its value is the rounded quotient of the sum of those three `cell_avg` lanes divided by 3.
- R5: `all_avg` is the rounded quotient of the sum of the three `clus_avg` lanes divided by 3.
- R6: `out_valid` rises at the publication of the 33rd snapshot accepted after reset and stays high until the next reset.
- R7: A strobe that arrives before the previous snapshot has been published is ignored. Its data never enters any filter.
- R8: A full-scale input of 4095 on every channel, held for 33 snapshots, yields 4095 on every output. The running sums do not overflow.
- R9: A sample leaves its filter window after exactly 33 further snapshots. After 33 zero snapshots, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Snapshot strobe, one cycle wide |
| smp_data | input | 108 | Nine unsigned 12-bit cell samples |
| cell_avg | output | 108 | Nine filtered cell voltages |
| clus_avg | output | 36 | Three cluster means |
| all_avg | output | 12 | Overall mean |
| out_valid | output | 1 | Filter windows are full |

## Verification
The assertions check four properties on every cycle:
- each cluster mean lies between the smallest and largest of its three cells;
- the overall mean lies between the cluster means;
- the outputs move only at a publish edge;
- the valid flag never drops once it has risen.

The exact rounding, the 33-snapshot window and its slide, the full-scale case and the rejection of early strobes are shown only by the bench's scenarios. The bench compares them against a reference model built from sample histories.

// File: rtl/cell_dc_avg.sv
module cell_dc_avg #(
  parameter int W     = 12,
  parameter int NCL   = 3,
  parameter int NCELL = 3,
  parameter int TAPS  = 33
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_stb,
  input  logic [NCL*NCELL*W-1:0] smp_data,
  output logic [NCL*NCELL*W-1:0] cell_avg,
  output logic [NCL*W-1:0]       clus_avg,
  output logic [W-1:0]           all_avg,
  output logic                   out_valid
);
  localparam int NCH = NCL * NCELL;
  localparam int CHW = $clog2(NCH);
  localparam int AW  = $clog2(TAPS);
  localparam int CNW = $clog2(TAPS + 1);
  localparam int IW  = $clog2(NCH * TAPS);
  localparam int SW  = W + $clog2(TAPS);
  localparam int SF  = SW + $clog2(TAPS);
  localparam int PW  = SW + SF + 1;
  localparam logic [SF:0] KF = (SF+1)'(((64'd1 << SF) + 64'(TAPS) - 64'd1) / 64'(TAPS));
  localparam int CW  = W + $clog2(NCELL) + 1;
  localparam int SC  = CW + $clog2(NCELL);
  localparam int CPW = CW + SC + 1;
  localparam logic [SC:0] KC = (SC+1)'(((64'd1 << SC) + 64'(NCELL) - 64'd1) / 64'(NCELL));
  localparam int OW  = W + $clog2(NCL) + 1;
  localparam int SO  = OW + $clog2(NCL);
  localparam int OPW = OW + SO + 1;
  localparam logic [SO:0] KO = (SO+1)'(((64'd1 << SO) + 64'(NCL) - 64'd1) / 64'(NCL));

  logic [W-1:0]       win_q [NCH*TAPS];
  logic [SW-1:0]      sum_q [NCH];
  logic [W-1:0]       fil_q [NCH];
  logic [NCH*W-1:0]   smp_q;
  logic [CHW-1:0]     ch;
  logic [AW-1:0]      wp;
  logic [CNW-1:0]     cnt;
  logic               busy, fin;

  logic [IW-1:0]      idx;
  logic [W-1:0]       x_cur, x_old;
  logic [SW-1:0]      sum_nx;
  logic [PW-1:0]      pf;

  assign idx    = IW'(ch) * IW'(TAPS) + IW'(wp);
  assign x_cur  = smp_q[ch*W +: W];
  assign x_old  = win_q[idx];
  assign sum_nx = sum_q[ch] + SW'(x_cur) - SW'(x_old);
  assign pf     = PW'(sum_nx + SW'(TAPS / 2)) * PW'(KF);

  logic [CW-1:0]  csum [NCL];
  logic [CPW-1:0] cprod [NCL];
  logic [W-1:0]   cav [NCL];
  logic [OW-1:0]  osum;
  logic [OPW-1:0] oprod;

  always_comb begin
    osum = '0;
    for (int k = 0; k < NCL; k++) begin
      csum[k] = '0;
      for (int j = 0; j < NCELL; j++) csum[k] = csum[k] + CW'(fil_q[k*NCELL+j]);
      cprod[k] = CPW'(csum[k] + CW'(NCELL / 2)) * CPW'(KC);
      cav[k]   = cprod[k][SC +: W];
      osum     = osum + OW'(cav[k]);
    end
    oprod = OPW'(osum + OW'(NCL / 2)) * OPW'(KO);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH*TAPS; i++) win_q[i] <= '0;
      for (int i = 0; i < NCH; i++) begin
        sum_q[i] <= '0;
        fil_q[i] <= '0;
      end
      smp_q     <= '0;
      ch        <= '0;
      wp        <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      fin       <= 1'b0;
      cell_avg  <= '0;
      clus_avg  <= '0;
      all_avg   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (!busy && !fin && smp_stb) begin
        smp_q <= smp_data;
        ch    <= '0;
        busy  <= 1'b1;
      end
      if (busy) begin
        win_q[idx] <= x_cur;
        sum_q[ch]  <= sum_nx;
        fil_q[ch]  <= pf[SF +: W];
        if (ch == CHW'(NCH - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
          wp   <= (wp == AW'(TAPS - 1)) ? '0 : wp + 1'b1;
        end else begin
          ch <= ch + 1'b1;
        end
      end
      if (fin) begin
        fin <= 1'b0;
        for (int i = 0; i < NCH; i++) cell_avg[i*W +: W] <= fil_q[i];
        for (int k = 0; k < NCL; k++) clus_avg[k*W +: W] <= cav[k];
        all_avg <= oprod[SO +: W];
        if (cnt != CNW'(TAPS)) cnt <= cnt + 1'b1;
        if (cnt >= CNW'(TAPS - 1)) out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_dc_avg_chk.sv
module cell_dc_avg_chk #(
  parameter int W     = 12,
  parameter int NCL   = 3,
  parameter int NCELL = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fin,
  input logic [NCL*NCELL*W-1:0] cell_avg,
  input logic [NCL*W-1:0]       clus_avg,
  input logic [W-1:0]           all_avg,
  input logic                   out_valid
);
  logic [W-1:0] cmin [NCL];
  logic [W-1:0] cmax [NCL];
  logic [W-1:0] kmin, kmax;

  always_comb begin
    kmin = '1;
    kmax = '0;
    for (int k = 0; k < NCL; k++) begin
      cmin[k] = '1;
      cmax[k] = '0;
      for (int j = 0; j < NCELL; j++) begin
        if (cell_avg[(k*NCELL+j)*W +: W] < cmin[k]) cmin[k] = cell_avg[(k*NCELL+j)*W +: W];
        if (cell_avg[(k*NCELL+j)*W +: W] > cmax[k]) cmax[k] = cell_avg[(k*NCELL+j)*W +: W];
      end
      if (clus_avg[k*W +: W] < kmin) kmin = clus_avg[k*W +: W];
      if (clus_avg[k*W +: W] > kmax) kmax = clus_avg[k*W +: W];
    end
  end

  for (genvar k = 0; k < NCL; k++) begin : g_cl
    p_clus_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clus_avg[k*W +: W] >= cmin[k]) && (clus_avg[k*W +: W] <= cmax[k]));
  end

  p_all_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (all_avg >= kmin) && (all_avg <= kmax));

  p_hold_between_publish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(cell_avg) && $stable(clus_avg) && $stable(all_avg)));

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

bind cell_dc_avg cell_dc_avg_chk #(.W(W), .NCL(NCL), .NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .fin(fin), .cell_avg(cell_avg),
  .clus_avg(clus_avg), .all_avg(all_avg), .out_valid(out_valid)
);

// File: tb/cell_dc_avg_tb.sv
module cell_dc_avg_tb;
  localparam int TCLK = 10;
  localparam int NCH  = 9;
  localparam int TAPS = 33;
  localparam int NV   = 40;
  localparam logic [11:0] SEEDS [NV] = '{
    12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h123, 12'hABC, 12'h555, 12'hAAA,
    12'h0F0, 12'hF0F, 12'h321, 12'hFED, 12'h001, 12'hFFE, 12'h400, 12'hC00,
    12'h3C3, 12'h9A9, 12'h6B6, 12'h777, 12'h888, 12'h042, 12'hE11, 12'h2D2,
    12'hB4B, 12'h5A5, 12'h0AA, 12'hF55, 12'h1E1, 12'hD1D, 12'h606, 12'h909,
    12'h3FF, 12'hC01, 12'h0CC, 12'hF33, 12'h246, 12'h8AC, 12'hDB9, 12'h135
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_stb = 1'b0;
  logic [107:0] smp_data = '0;
  logic [107:0] cell_avg;
  logic [35:0]  clus_avg;
  logic [11:0]  all_avg;
  logic         out_valid;

  int n_chk = 0;
  int n_bad = 0;
  int hist [NCH][TAPS];
  int head = 0;
  int nacc = 0;
  int e_cell [NCH];
  int e_cl [3];
  int e_all = 0;
  bit e_val = 0;

  always #(TCLK/2) clk = ~clk;

  cell_dc_avg u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .cell_avg(cell_avg), .clus_avg(clus_avg), .all_avg(all_avg), .out_valid(out_valid)
  );

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < TAPS; t++) hist[c][t] = 0;
      e_cell[c] = 0;
    end
    for (int k = 0; k < 3; k++) e_cl[k] = 0;
    e_all = 0; e_val = 0; head = 0; nacc = 0;
  endtask

  task automatic model_push(input logic [107:0] d);
    int s;
    for (int c = 0; c < NCH; c++) hist[c][head] = int'(d[c*12 +: 12]);
    head = (head + 1) % TAPS;
    nacc++;
    for (int c = 0; c < NCH; c++) begin
      s = 0;
      for (int t = 0; t < TAPS; t++) s += hist[c][t];
      e_cell[c] = (s + TAPS/2) / TAPS;
    end
    s = 0;
    for (int k = 0; k < 3; k++) begin
      e_cl[k] = (e_cell[3*k] + e_cell[3*k+1] + e_cell[3*k+2] + 1) / 3;
      s += e_cl[k];
    end
    e_all = (s + 1) / 3;
    e_val = (nacc >= TAPS);
  endtask

  task automatic check_all(input string req);
    int bad_c, bad_k;
    bad_c = -1; bad_k = -1;
    for (int c = 0; c < NCH; c++)
      if (int'(cell_avg[c*12 +: 12]) != e_cell[c] && bad_c < 0) bad_c = c;
    n_chk++;
    if (bad_c >= 0) begin
      n_bad++;
      $display("FAIL %s/R2 cell %0d: got %0d exp %0d", req, bad_c, cell_avg[bad_c*12 +: 12], e_cell[bad_c]);
    end
    for (int k = 0; k < 3; k++)
      if (int'(clus_avg[k*12 +: 12]) != e_cl[k] && bad_k < 0) bad_k = k;
    n_chk++;
    if (bad_k >= 0) begin
      n_bad++;
      $display("FAIL %s/R4 cluster %0d: got %0d exp %0d", req, bad_k, clus_avg[bad_k*12 +: 12], e_cl[bad_k]);
    end
    n_chk++;
    if (int'(all_avg) != e_all) begin
      n_bad++;
      $display("FAIL %s/R5 overall: got %0d exp %0d", req, all_avg, e_all);
    end
    n_chk++;
    if (out_valid != e_val) begin
      n_bad++;
      $display("FAIL %s/R6 valid: got %0b exp %0b", req, out_valid, e_val);
    end
  endtask

  task automatic apply(input logic [107:0] d, input string req, input bit poke_busy);
    @(negedge clk);
    smp_stb = 1'b1; smp_data = d;
    @(negedge clk);
    smp_stb = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      smp_stb = 1'b1; smp_data = ~d;
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (7) @(posedge clk);
    end else begin
      repeat (9) @(posedge clk);
    end
    @(negedge clk);
    check_all("R3 hold");
    model_push(d);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [107:0] pattern(input logic [11:0] seed);
    logic [107:0] d;
    for (int c = 0; c < NCH; c++) d[c*12 +: 12] = seed ^ (12'(c) * 12'h1C3);
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");

    for (int v = 0; v < NV; v++) apply(pattern(SEEDS[v]), "R2 table", 1'b0);

    apply(pattern(12'h5C7), "R7 busy strobe", 1'b1);
    apply(pattern(12'h0E3), "R7 after busy", 1'b0);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_clear();
    check_all("R1 mid reset");
    rst_n = 1'b1;
    for (int v = 0; v < TAPS; v++) apply({9{12'hFFF}}, v == TAPS-1 ? "R8 full" : "R6 fill", 1'b0);
    n_chk++;
    if (all_avg != 12'hFFF || cell_avg != {9{12'hFFF}} || clus_avg != {3{12'hFFF}}) begin
      n_bad++;
      $display("FAIL R8 full scale: got %0h exp fff", all_avg);
    end
    for (int v = 0; v < TAPS; v++) apply('0, "R9 slide", 1'b0);
    n_chk++;
    if (cell_avg != '0 || clus_avg != '0 || all_avg != '0) begin
      n_bad++;
      $display("FAIL R9 drained: got %0h exp 0", all_avg);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule